// File: doc/BRIEF.md
# Single-Channel Bus-Mastering DMA Controller

This block moves a block of bytes between one peripheral and system memory without the CPU copying each byte. Software loads a start address and a byte count, then writes a control word that picks the direction and the way the bus is taken, and sets the go bit. The controller drives a simple synchronous memory port: one address, a read or a write strobe, and a byte of data per transfer. Each byte is paced by the peripheral's request line and answered with a one-cycle acknowledge. When the last byte has moved, a sticky interrupt flag is raised. Software clears it by writing a one.

Three ways of taking the bus are offered. Block mode requests the bus once and keeps it until the whole block has moved. Steal mode gives the bus back after every byte and asks for it again for the next byte. Hidden mode never requests the bus. It moves a byte only in a cycle that the CPU marks as leaving the bus unused.

Top module: `dma_single_ch`

## Requirements
- R1: Register select 0 holds the memory address and select 1 holds the byte count. Each reads back what was last written. A write to either one is ignored while a transfer is busy.
- R2: Each transferred byte raises the address by one and lowers the remaining count by one. At completion the address reads as start plus length and the count reads as zero.
- R3: The memory read and write strobes are active only in two cases: a cycle where both bus_req and bus_grant are high, or a cycle in hidden mode where cpu_idle is high.
- R4: Block mode is control field [2:1] = 0, and the reserved value 3 behaves the same way. In this mode bus_req rises once per block, stays high until the last byte, and falls in the cycle after that byte.
- R5: Steal mode is control field [2:1] = 1. In this mode bus_req falls in the cycle after every byte, so it rises once per byte.
- R6: Hidden mode is control field [2:1] = 2. In this mode bus_req is never asserted.
- R7: Completion sets the interrupt flag, which is read at control bit 4 and driven on irq. The flag stays set until a control write with bit 4 = 1 clears it. If a set and a clear happen in the same cycle, the set wins.
- R8: A go with a count of zero sets the interrupt flag at the same edge. No bus request is made and the block never becomes busy.
- R9: A byte moves only in a cycle where dev_req is high. Every moved byte gives exactly one dev_ack cycle.
- R10: Control bit 3 selects the direction. When it is 1, dev_rdata is written to memory. When it is 0, mem_rdata is read and handed out on dev_wdata.
- R11: Control bit 0 starts a transfer when written as 1. On read, control bit 0 shows busy, which is 1 from the go edge until the last byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_sel | input | 2 | Register select: 0 address, 1 count, 2 control/status |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | REG_W | Register write data |
| reg_rdata | output | REG_W | Register read data for reg_sel, combinational |
| irq | output | 1 | Completion interrupt flag |
| bus_req | output | 1 | Bus request to the CPU side |
| bus_grant | input | 1 | Bus grant from the CPU side |
| cpu_idle | input | 1 | CPU marks the bus as unused in this cycle |
| mem_addr | output | ADDR_W | Memory address, zero when no byte moves |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_wdata | output | 8 | Byte written to memory |
| mem_rdata | input | 8 | Byte read from memory, valid in the strobe cycle |
| dev_req | input | 1 | Peripheral has data or space for one byte |
| dev_ack | output | 1 | One-cycle acknowledge per moved byte |
| dev_rdata | input | 8 | Byte from the peripheral |
| dev_wdata | output | 8 | Byte to the peripheral |

## Verification
The strobe property for R3 assumes a grant that answers a request and is taken away once the request falls. The bench CPU model keeps to this by registering bus_req into bus_grant, so the grant trails the request by one cycle in both directions. The properties place no constraint on dev_req or cpu_idle. The bench drives them as periodic patterns that are sometimes always high and sometimes sparse, so that transfers stall and resume at many points. The cursor property assumes no load arrives while a byte steps. The stimulus tests this by writing the address and count registers in the middle of a transfer.

// File: rtl/dma_pkg.sv
package dma_pkg;

  typedef enum logic [1:0] {
    XM_BLOCK  = 2'd0,
    XM_STEAL  = 2'd1,
    XM_HIDDEN = 2'd2,
    XM_RSVD   = 2'd3
  } xfer_mode_e;

  typedef enum logic [1:0] {
    SQ_IDLE,
    SQ_HOLD,
    SQ_GAP,
    SQ_HIDE
  } seq_state_e;

  localparam logic [1:0] SEL_ADDR = 2'd0;
  localparam logic [1:0] SEL_CNT  = 2'd1;
  localparam logic [1:0] SEL_CTRL = 2'd2;

  localparam int CB_GO   = 0;
  localparam int CB_MODE = 1;
  localparam int CB_DIR  = 3;
  localparam int CB_IRQ  = 4;

  // reserved encoding folds onto block mode
  function automatic xfer_mode_e decode_mode(input logic [1:0] f);
    return (f == 2'd3) ? XM_BLOCK : xfer_mode_e'(f);
  endfunction

endpackage

// File: rtl/dma_cursor.sv
module dma_cursor #(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_addr,
  input  logic              load_cnt,
  input  logic [ADDR_W-1:0] new_addr,
  input  logic [CNT_W-1:0]  new_cnt,
  input  logic              step,
  output logic [ADDR_W-1:0] addr,
  output logic [CNT_W-1:0]  cnt,
  output logic              cnt_last,
  output logic              cnt_empty
);

  function automatic logic [ADDR_W-1:0] adv_addr(input logic [ADDR_W-1:0] a);
    return a + ADDR_W'(1);
  endfunction

  function automatic logic [CNT_W-1:0] dec_cnt(input logic [CNT_W-1:0] c);
    return c - CNT_W'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr <= '0;
      cnt  <= '0;
    end else begin
      if (load_addr) addr <= new_addr;
      else if (step) addr <= adv_addr(addr);
      if (load_cnt)  cnt <= new_cnt;
      else if (step) cnt <= dec_cnt(cnt);
    end
  end

  assign cnt_last  = (cnt == CNT_W'(1));
  assign cnt_empty = (cnt == '0);

  p_addr_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> addr == ADDR_W'($past(addr) + ADDR_W'(1)));
  p_cnt_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> cnt == CNT_W'($past(cnt) - CNT_W'(1)));
  p_addr_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_addr && !step) |=> $stable(addr));
  p_no_load_in_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> !(load_addr || load_cnt));

endmodule

// File: rtl/dma_regs.sv
module dma_regs
  import dma_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16,
  parameter int REG_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        reg_sel,
  input  logic              reg_wr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic              busy,
  input  logic              done,
  input  logic [ADDR_W-1:0] cur_addr,
  input  logic [CNT_W-1:0]  cur_cnt,
  output logic              load_addr,
  output logic              load_cnt,
  output logic              go,
  output xfer_mode_e        go_mode,
  output xfer_mode_e        mode,
  output logic              dir_to_mem,
  output logic              irq_flag
);

  logic wr_ctrl, irq_clr;

  assign wr_ctrl   = reg_wr && (reg_sel == SEL_CTRL);
  assign irq_clr   = wr_ctrl && reg_wdata[CB_IRQ];
  assign load_addr = reg_wr && (reg_sel == SEL_ADDR) && !busy;
  assign load_cnt  = reg_wr && (reg_sel == SEL_CNT) && !busy;
  assign go        = wr_ctrl && reg_wdata[CB_GO] && !busy;
  assign go_mode   = decode_mode(reg_wdata[CB_MODE+1:CB_MODE]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode       <= XM_BLOCK;
      dir_to_mem <= 1'b0;
      irq_flag   <= 1'b0;
    end else begin
      if (go) begin
        mode       <= go_mode;
        dir_to_mem <= reg_wdata[CB_DIR];
      end
      if (done)         irq_flag <= 1'b1;
      else if (irq_clr) irq_flag <= 1'b0;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_sel)
      SEL_ADDR: reg_rdata[ADDR_W-1:0] = cur_addr;
      SEL_CNT:  reg_rdata[CNT_W-1:0]  = cur_cnt;
      SEL_CTRL: begin
        reg_rdata[CB_GO]               = busy;
        reg_rdata[CB_MODE+1:CB_MODE]   = mode;
        reg_rdata[CB_DIR]              = dir_to_mem;
        reg_rdata[CB_IRQ]              = irq_flag;
      end
      default: reg_rdata = '0;
    endcase
  end

  p_irq_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> irq_flag);
  p_irq_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_flag && !irq_clr) |=> irq_flag);

endmodule

// File: rtl/dma_seq.sv
module dma_seq
  import dma_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       go,
  input  xfer_mode_e go_mode,
  input  xfer_mode_e mode,
  input  logic       cnt_empty,
  input  logic       cnt_last,
  input  logic       bus_grant,
  input  logic       cpu_idle,
  input  logic       dev_req,
  output logic       bus_req,
  output logic       step,
  output logic       busy,
  output logic       done
);

  seq_state_e st, st_n;
  logic may_move, last_step, zero_go;

  always_comb begin
    may_move = 1'b0;
    case (st)
      SQ_HOLD: may_move = bus_grant;
      SQ_HIDE: may_move = cpu_idle;
      default: may_move = 1'b0;
    endcase
  end

  assign step      = may_move && dev_req;
  assign last_step = step && cnt_last;
  assign zero_go   = go && cnt_empty;
  assign done      = zero_go || last_step;
  assign bus_req   = (st == SQ_HOLD);
  assign busy      = (st != SQ_IDLE);

  always_comb begin
    st_n = st;
    case (st)
      SQ_IDLE: if (go && !cnt_empty) st_n = (go_mode == XM_HIDDEN) ? SQ_HIDE : SQ_HOLD;
      SQ_HOLD: if (step) st_n = cnt_last ? SQ_IDLE : ((mode == XM_STEAL) ? SQ_GAP : SQ_HOLD);
      SQ_GAP:  st_n = SQ_HOLD;
      SQ_HIDE: if (last_step) st_n = SQ_IDLE;
      default: st_n = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st <= SQ_IDLE;
    else        st <= st_n;
  end

  p_block_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && mode != XM_STEAL && !last_step) |=> bus_req);
  p_block_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
    last_step |=> !busy && !bus_req);
  p_steal_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (step && mode == XM_STEAL) |=> !bus_req);
  p_hidden_no_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && mode == XM_HIDDEN) |-> !bus_req);
  p_zero_count_r8: assert property (@(posedge clk) disable iff (!rst_n)
    zero_go |=> !busy && !bus_req);
  p_busy_after_go_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (go && !cnt_empty) |=> busy);

endmodule

// File: rtl/dma_single_ch.sv
module dma_single_ch
  import dma_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16,
  parameter int REG_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        reg_sel,
  input  logic              reg_wr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  output logic              irq,
  output logic              bus_req,
  input  logic              bus_grant,
  input  logic              cpu_idle,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [7:0]        mem_wdata,
  input  logic [7:0]        mem_rdata,
  input  logic              dev_req,
  output logic              dev_ack,
  input  logic [7:0]        dev_rdata,
  output logic [7:0]        dev_wdata
);

  logic              load_addr, load_cnt, go, busy, done, step;
  logic              cnt_last, cnt_empty, dir_to_mem, irq_flag;
  logic [ADDR_W-1:0] cur_addr;
  logic [CNT_W-1:0]  cur_cnt;
  xfer_mode_e        go_mode, mode;

  dma_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .REG_W(REG_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy(busy), .done(done),
    .cur_addr(cur_addr), .cur_cnt(cur_cnt), .load_addr(load_addr),
    .load_cnt(load_cnt), .go(go), .go_mode(go_mode), .mode(mode),
    .dir_to_mem(dir_to_mem), .irq_flag(irq_flag)
  );

  dma_cursor #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_cursor (
    .clk(clk), .rst_n(rst_n), .load_addr(load_addr), .load_cnt(load_cnt),
    .new_addr(reg_wdata[ADDR_W-1:0]), .new_cnt(reg_wdata[CNT_W-1:0]),
    .step(step), .addr(cur_addr), .cnt(cur_cnt), .cnt_last(cnt_last),
    .cnt_empty(cnt_empty)
  );

  dma_seq u_seq (
    .clk(clk), .rst_n(rst_n), .go(go), .go_mode(go_mode), .mode(mode),
    .cnt_empty(cnt_empty), .cnt_last(cnt_last), .bus_grant(bus_grant),
    .cpu_idle(cpu_idle), .dev_req(dev_req), .bus_req(bus_req), .step(step),
    .busy(busy), .done(done)
  );

  assign mem_addr  = step ? cur_addr : '0;
  assign mem_wr    = step && dir_to_mem;
  assign mem_rd    = step && !dir_to_mem;
  assign mem_wdata = dev_rdata;
  assign dev_wdata = mem_rdata;
  assign dev_ack   = step;
  assign irq       = irq_flag;

  p_strobe_owner_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd || mem_wr) |-> ((bus_req && bus_grant) || (mode == XM_HIDDEN && cpu_idle)));
  p_ack_paced_r9: assert property (@(posedge clk) disable iff (!rst_n)
    dev_ack |-> dev_req);
  p_one_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));

endmodule

// File: tb/sim_dma_single_ch.sv
module sim_dma_single_ch;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int AW = 16, CW = 16, RW = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [1:0]    reg_sel;
  logic          reg_wr;
  logic [RW-1:0] reg_wdata, reg_rdata;
  logic          irq, bus_req, bus_grant, cpu_idle;
  logic [AW-1:0] mem_addr;
  logic          mem_rd, mem_wr;
  logic [7:0]    mem_wdata, mem_rdata;
  logic          dev_req, dev_ack;
  logic [7:0]    dev_rdata, dev_wdata;

  always #10 clk = ~clk;

  dma_single_ch #(.ADDR_W(AW), .CNT_W(CW), .REG_W(RW)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .bus_req(bus_req), .bus_grant(bus_grant), .cpu_idle(cpu_idle),
    .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .dev_req(dev_req),
    .dev_ack(dev_ack), .dev_rdata(dev_rdata), .dev_wdata(dev_wdata)
  );

  int n_checks = 0, n_fail = 0;
  int cyc = 0, ack_cnt = 0, req_rises = 0, viol = 0;
  bit preload = 0, clr_mon = 0, slow_req = 0, sparse_idle = 0;
  int mode_now = 0;
  logic req_q = 1'b0;
  logic [7:0] mem [256];
  logic [7:0] rx [16];

  function automatic logic [7:0] pre_byte(input int a);
    return 8'((a * 7) + 3);
  endfunction
  function automatic logic [7:0] src_byte(input int k);
    return 8'h5A ^ 8'(k * 13);
  endfunction

  assign mem_rdata = mem[mem_addr[7:0]];
  assign dev_rdata = src_byte(ack_cnt);
  assign dev_req   = slow_req ? (cyc % 3 != 0) : 1'b1;
  assign cpu_idle  = sparse_idle ? (cyc % 4 == 2) : 1'b1;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    bus_grant <= rst_n ? bus_req : 1'b0;
    if (preload) begin
      for (int i = 0; i < 256; i++) mem[i] <= pre_byte(i);
    end else if (mem_wr) mem[mem_addr[7:0]] <= mem_wdata;
    if (clr_mon) begin
      ack_cnt <= 0; req_rises <= 0; viol <= 0; req_q <= 1'b0;
    end else begin
      req_q <= bus_req;
      if (bus_req && !req_q) req_rises <= req_rises + 1;
      if (dev_ack) begin
        rx[ack_cnt[3:0]] <= dev_wdata;
        ack_cnt <= ack_cnt + 1;
      end
      if ((mem_rd || mem_wr) && !((bus_req && bus_grant) || (mode_now == 2 && cpu_idle)))
        viol <= viol + 1;
      if (dev_ack && !dev_req) viol <= viol + 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic reg_write(input logic [1:0] sel, input int data);
    @(negedge clk);
    reg_sel = sel; reg_wdata = RW'(data); reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [1:0] sel, output int val);
    reg_sel = sel;
    #1;
    val = int'(reg_rdata);
  endtask

  task automatic pulse(ref bit b);
    @(negedge clk); b = 1'b1;
    @(negedge clk); b = 1'b0;
  endtask

  task automatic run(input int mode, input int dir, input int base, input int n, input bit poke);
    int v, bad, exp_rises;
    mode_now = (mode == 3) ? 0 : mode;
    pulse(preload);
    pulse(clr_mon);
    reg_write(2'd0, base);
    reg_write(2'd1, n);
    reg_read(2'd0, v); chk(v == base, "R1 address readback", v, base);
    reg_read(2'd1, v); chk(v == n, "R1 count readback", v, n);
    reg_write(2'd2, 1 | (mode << 1) | (dir << 3));
    if (poke) begin
      reg_read(2'd2, v); chk(v[0] == 1'b1, "R11 busy during transfer", v[0], 1);
      reg_write(2'd0, 16'hFFF0);
      reg_write(2'd1, 3);
    end
    for (int t = 0; t < 4000 && !irq; t++) @(negedge clk);
    chk(irq == 1'b1, "R7 irq at completion", irq, 1);
    reg_read(2'd0, v); chk(v == base + n, "R2 final address", v, base + n);
    reg_read(2'd1, v); chk(v == 0, "R2 final count", v, 0);
    reg_read(2'd2, v); chk(v[0] == 1'b0, "R11 busy cleared", v[0], 0);
    chk(v[3] == dir[0], "R10 direction readback", v[3], dir);
    chk(ack_cnt == n, "R9 one ack per byte", ack_cnt, n);
    chk(viol == 0, "R3 strobe only with bus owned", viol, 0);
    exp_rises = (mode_now == 0) ? 1 : (mode_now == 1) ? n : 0;
    chk(req_rises == exp_rises, mode_now == 0 ? "R4 block request count" :
        mode_now == 1 ? "R5 steal request count" : "R6 hidden request count",
        req_rises, exp_rises);
    chk(bus_req == 1'b0, "R4 request dropped after block", bus_req, 0);
    bad = 0;
    for (int i = 0; i < n; i++) begin
      if (dir == 1) begin
        if (mem[base + i] !== src_byte(i)) bad++;
      end else begin
        if (rx[i] !== pre_byte(base + i)) bad++;
      end
    end
    chk(bad == 0, "R10 data moved", bad, 0);
    repeat (3) @(negedge clk);
    chk(irq == 1'b1, "R7 irq sticky", irq, 1);
    reg_write(2'd2, 16);
    chk(irq == 1'b0, "R7 irq cleared by write-one", irq, 0);
  endtask

  initial begin
    int v, lens[3];
    lens = '{1, 3, 6};
    rst_n = 1'b0; reg_sel = 2'd0; reg_wr = 1'b0; reg_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(irq == 1'b0 && bus_req == 1'b0, "R7 reset idle outputs", {irq, bus_req}, 0);
    reg_read(2'd2, v); chk(v == 0, "R11 reset control", v, 0);

    for (int m = 0; m < 4; m++)
      for (int d = 0; d < 2; d++)
        for (int li = 0; li < 3; li++) begin
          slow_req    = (li == 1) || (d == 1 && li == 2);
          sparse_idle = (li != 0);
          run(m, d, 8 * (m * 6 + d * 3 + li) + 4, lens[li], li == 2);
        end

    // zero-length block
    mode_now = 0;
    pulse(clr_mon);
    reg_write(2'd1, 0);
    reg_write(2'd2, 1);
    chk(irq == 1'b1, "R8 zero count irq at once", irq, 1);
    reg_read(2'd2, v); chk(v[0] == 1'b0, "R8 zero count never busy", v[0], 0);
    repeat (5) @(negedge clk);
    chk(req_rises == 0, "R8 zero count no request", req_rises, 0);
    reg_write(2'd2, 16);
    chk(irq == 1'b0, "R7 clear after zero count", irq, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule